// File: doc/BRIEF.md
# Asynchronous Event Request Manager

This block sits in the admin path of a storage controller and pairs two kinds of waiting items. Host software parks event-request commands with the controller; they stay outstanding until the controller has something to report. Independently, controller logic posts events (an error seen on a doorbell write, a crossed health threshold, and so on). Each event waits in a bounded pending queue until a request can carry it back. When both exist, the block emits one completion record that carries the request's command identifier, a success status and the three event fields.

The block masks each event type after it is reported. A type stays masked until the log-read path raises a clear for it. Masked events remain queued but do not hold back younger events of other types. Requests beyond the configured limit are refused through a separate reject strobe. A controller reset discards all waiting requests and events. Queue memory, doorbells, DMA and command decoding belong to neighbouring blocks.

Top module: `aer_manager`

## Requirements
- R1: A request that arrives while REQ_LIMIT+1 requests are outstanding (count taken before any completion in that cycle) is refused. One cycle later `rej_valid` pulses with its identifier and `rej_status` = 8'h05. The refused request is never completed.
- R2: An accepted request produces no output of its own. It stays outstanding until an event is matched to it.
- R3: Outstanding requests are used newest first: every completion carries the identifier of the most recently accepted request that is still outstanding.
- R4: The pending queue holds QDEPTH events. An event posted while QDEPTH are already queued is discarded and never appears in any completion.
- R5: Of the queued events, the oldest one whose type is unmasked is reported first. Masked events keep their place and do not block younger unmasked ones.
- R6: A completion carries status 8'h00 and the event's type, info and log-page bytes unchanged. Reporting sets the mask bit indexed by type bits [2:0]; event types are 0 to 7.
- R7: Matching runs whenever a request is outstanding and an unmasked event is queued. A post, a request or a clear sampled on clock edge k can yield a completion that is valid after edge k+1.
- R8: `clr_valid` with `clr_type` unmasks that type. Queued events of that type then become eligible. If a completion of the same type is issued in the same cycle, the mask bit stays set.
- R9: `ctrl_reset` empties the pending queue, drops all outstanding requests and withdraws any completion awaiting acceptance. The mask is kept. Other inputs in that cycle are ignored.
- R10: At most one completion is issued per cycle. While `cpl_valid` is high and `cpl_ready` is low, every completion output holds its value.
- R11: After `rst_n` is low, no request or event is held, every type is unmasked, and `cpl_valid` and `rej_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reset | input | 1 | Synchronous controller reset |
| req_valid | input | 1 | Event-request command arrival strobe |
| req_cid | input | CID_W | Command identifier of the arriving request |
| evt_valid | input | 1 | Event post strobe |
| evt_type | input | 8 | Event type (0 to 7) |
| evt_info | input | 8 | Event information code |
| evt_lid | input | 8 | Associated log-page identifier |
| clr_valid | input | 1 | Type clear strobe from the log-read path |
| clr_type | input | 3 | Type to unmask |
| cpl_valid | output | 1 | Completion record valid |
| cpl_ready | input | 1 | Completion accepted by the admin completion path |
| cpl_cid | output | CID_W | Identifier of the completed request |
| cpl_status | output | 8 | Completion status (8'h00) |
| cpl_type | output | 8 | Reported event type |
| cpl_info | output | 8 | Reported event info |
| cpl_lid | output | 8 | Reported log-page identifier |
| rej_valid | output | 1 | Request refused over the limit |
| rej_cid | output | CID_W | Identifier of the refused request |
| rej_status | output | 8 | Refusal status (8'h05) |

## Verification
The assertions assume that `evt_type` stays within 0 to 7. They also assume that the completion consumer does not depend on a completion surviving `ctrl_reset`, since the hold property is disabled in a reset cycle. The stimulus posts only types 0 to 7 and raises `cpl_ready` or `ctrl_reset` only on a falling edge. The behavioural reference in the bench applies the same ordering inside a cycle as the requirements: a completion pops before a request pushes, and a refusal is decided on the count before the pop. That keeps collisions of post, request and clear comparable on every clock.

// File: rtl/aer_pkg.sv
package aer_pkg;

    typedef struct packed {
        logic [7:0] etype;
        logic [7:0] info;
        logic [7:0] lid;
    } aer_evt_t;

    localparam logic [7:0] AER_STS_OK    = 8'h00;
    localparam logic [7:0] AER_STS_LIMIT = 8'h05;

endpackage

// File: rtl/aer_req_stack.sv
module aer_req_stack #(
    parameter int DEPTH = 4,
    parameter int CID_W = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [CID_W-1:0] push_cid,
    input  logic             pop,
    output logic [CID_W-1:0] top_cid,
    output logic [CW-1:0]    count
);

    typedef struct packed {
        logic [DEPTH-1:0][CID_W-1:0] cid;
        logic [CW-1:0]               cnt;
    } stk_t;

    stk_t st_d, st_q;
    logic [CW-1:0] below;
    logic [CW-1:0] base;

    always_comb begin
        below   = st_q.cnt - CW'(1);
        top_cid = (st_q.cnt != '0) ? st_q.cid[below[IW-1:0]] : '0;
        count   = st_q.cnt;

        st_d = st_q;
        base = pop ? below : st_q.cnt;
        if (push) begin
            st_d.cid[base[IW-1:0]] = push_cid;
            base = base + CW'(1);
        end
        st_d.cnt = flush ? '0 : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (st_q.cnt < CW'(DEPTH))); // R1
    AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0)); // R3
    AST_STACK_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush) |=> (count == $past(count) - CW'(1))); // R3

endmodule

// File: rtl/aer_evt_queue.sv
module aer_evt_queue
    import aer_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     push,
    input  aer_evt_t push_evt,
    input  logic [7:0] mask,
    input  logic     take,
    output logic     hit,
    output aer_evt_t hit_evt
);

    typedef struct packed {
        aer_evt_t [DEPTH-1:0] slot;
        logic [CW-1:0]        cnt;
    } evq_t;

    evq_t st_d, st_q;
    logic [IW-1:0] hit_idx;
    logic [CW-1:0] base;

    // oldest queued entry whose type is not masked
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit && (CW'(i) < st_q.cnt) && !mask[st_q.slot[i].etype[2:0]]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
        hit_evt = st_q.slot[hit_idx];
    end

    always_comb begin
        st_d = st_q;
        base = st_q.cnt;
        if (take) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IW'(i) >= hit_idx) st_d.slot[i] = st_q.slot[i+1];
            end
            base = st_q.cnt - CW'(1);
        end
        if (push && (st_q.cnt != CW'(DEPTH))) begin
            st_d.slot[base[IW-1:0]] = push_evt;
            base = base + CW'(1);
        end
        st_d.cnt = flush ? '0 : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TAKE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hit); // R5
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R4
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !take && !flush && st_q.cnt == CW'(DEPTH)) |=> (st_q.cnt == CW'(DEPTH))); // R4

endmodule

// File: rtl/aer_manager.sv
module aer_manager
    import aer_pkg::*;
#(
    parameter int REQ_LIMIT = 3,
    parameter int QDEPTH    = 64,
    parameter int CID_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_reset,
    input  logic             req_valid,
    input  logic [CID_W-1:0] req_cid,
    input  logic             evt_valid,
    input  logic [7:0]       evt_type,
    input  logic [7:0]       evt_info,
    input  logic [7:0]       evt_lid,
    input  logic             clr_valid,
    input  logic [2:0]       clr_type,
    output logic             cpl_valid,
    input  logic             cpl_ready,
    output logic [CID_W-1:0] cpl_cid,
    output logic [7:0]       cpl_status,
    output logic [7:0]       cpl_type,
    output logic [7:0]       cpl_info,
    output logic [7:0]       cpl_lid,
    output logic             rej_valid,
    output logic [CID_W-1:0] rej_cid,
    output logic [7:0]       rej_status
);

    localparam int SDEPTH = REQ_LIMIT + 1;
    localparam int SCW    = $clog2(SDEPTH + 1);

    typedef struct packed {
        logic [7:0]       mask;
        logic             cpl_v;
        logic [CID_W-1:0] cpl_cid;
        aer_evt_t         cpl_evt;
        logic             rej_v;
        logic [CID_W-1:0] rej_cid;
    } mgr_t;

    mgr_t st_d, st_q;

    logic             fire, accept, post;
    logic             q_hit;
    aer_evt_t         q_evt;
    logic [CID_W-1:0] top_cid;
    logic [SCW-1:0]   out_cnt;
    logic             at_limit;

    always_comb begin
        at_limit = (out_cnt == SCW'(SDEPTH));
        fire     = !ctrl_reset && (out_cnt != '0) && q_hit && (!st_q.cpl_v || cpl_ready);
        accept   = !ctrl_reset && req_valid && !at_limit;
        post     = !ctrl_reset && evt_valid;

        st_d = st_q;
        if (ctrl_reset) begin
            st_d.cpl_v = 1'b0;
            st_d.rej_v = 1'b0;
        end else begin
            if (clr_valid) st_d.mask[clr_type] = 1'b0;
            if (fire) begin
                st_d.mask[q_evt.etype[2:0]] = 1'b1;
                st_d.cpl_v   = 1'b1;
                st_d.cpl_cid = top_cid;
                st_d.cpl_evt = q_evt;
            end else if (cpl_ready) begin
                st_d.cpl_v = 1'b0;
            end
            st_d.rej_v   = req_valid && at_limit;
            st_d.rej_cid = req_cid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    aer_req_stack #(.DEPTH(SDEPTH), .CID_W(CID_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ctrl_reset),
        .push     (accept),
        .push_cid (req_cid),
        .pop      (fire),
        .top_cid  (top_cid),
        .count    (out_cnt)
    );

    aer_evt_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ctrl_reset),
        .push     (post),
        .push_evt ('{etype: evt_type, info: evt_info, lid: evt_lid}),
        .mask     (st_q.mask),
        .take     (fire),
        .hit      (q_hit),
        .hit_evt  (q_evt)
    );

    assign cpl_valid  = st_q.cpl_v;
    assign cpl_cid    = st_q.cpl_cid;
    assign cpl_status = AER_STS_OK;
    assign cpl_type   = st_q.cpl_evt.etype;
    assign cpl_info   = st_q.cpl_evt.info;
    assign cpl_lid    = st_q.cpl_evt.lid;
    assign rej_valid  = st_q.rej_v;
    assign rej_cid    = st_q.rej_cid;
    assign rej_status = AER_STS_LIMIT;

    AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready && !ctrl_reset) |=>
        (cpl_valid && $stable(cpl_cid) && $stable(cpl_type) && $stable(cpl_info) && $stable(cpl_lid))); // R10
    AST_REJ_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> ($past(out_cnt) == SCW'(SDEPTH))); // R1
    AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset |=> (out_cnt == '0 && !cpl_valid && !rej_valid)); // R9
    AST_MASK_KEPT_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset |=> $stable(st_q.mask)); // R9

endmodule

// File: tb/aer_manager_test.sv
module aer_manager_test;

    localparam int CLK_PERIOD = 10;
    localparam int LIM = 3;
    localparam int QD  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_reset = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_cid = '0;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_type = '0, evt_info = '0, evt_lid = '0;
    logic        clr_valid = 1'b0;
    logic [2:0]  clr_type = '0;
    logic        cpl_ready = 1'b1;
    logic        cpl_valid, rej_valid;
    logic [15:0] cpl_cid, rej_cid;
    logic [7:0]  cpl_status, cpl_type, cpl_info, cpl_lid, rej_status;

    always #(CLK_PERIOD/2) clk = ~clk;

    aer_manager #(.REQ_LIMIT(LIM), .QDEPTH(QD), .CID_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_reset(ctrl_reset),
        .req_valid(req_valid), .req_cid(req_cid),
        .evt_valid(evt_valid), .evt_type(evt_type), .evt_info(evt_info), .evt_lid(evt_lid),
        .clr_valid(clr_valid), .clr_type(clr_type),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_cid(cpl_cid),
        .cpl_status(cpl_status), .cpl_type(cpl_type), .cpl_info(cpl_info), .cpl_lid(cpl_lid),
        .rej_valid(rej_valid), .rej_cid(rej_cid), .rej_status(rej_status)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";
    bit checking = 0;

    // behavioural reference
    logic [23:0] mq[$];
    int          ms[$];
    logic [7:0]  mmask = '0;
    logic        ecv = 0, erv = 0;
    logic [15:0] ecid = '0, ercid = '0;
    logic [23:0] eevt = '0;
    int          osz, qsz, fi;
    logic [7:0]  setb;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); ms.delete(); mmask = '0; ecv = 0; erv = 0;
        end else if (ctrl_reset) begin
            mq.delete(); ms.delete(); ecv = 0; erv = 0;
        end else begin
            osz = ms.size(); qsz = mq.size(); fi = -1; setb = '0;
            if (osz > 0 && (!ecv || cpl_ready)) begin
                for (int i = 0; i < qsz; i++)
                    if (fi < 0 && !mmask[mq[i][18:16]]) fi = i;
            end
            if (fi >= 0) begin
                ecv = 1; ecid = 16'(ms.pop_back()); eevt = mq[fi]; mq.delete(fi);
                setb[eevt[18:16]] = 1'b1;
            end else if (cpl_ready) ecv = 0;
            erv = req_valid && (osz == LIM + 1);
            ercid = req_cid;
            if (req_valid && osz < LIM + 1) ms.push_back(int'(req_cid));
            if (evt_valid && qsz < QD) mq.push_back({evt_type, evt_info, evt_lid});
            if (clr_valid) mmask[clr_type] = 1'b0;
            mmask = mmask | setb;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            chk(cpl_valid == ecv, cur_req, "cpl_valid", cpl_valid, ecv);
            if (ecv && cpl_valid) begin
                chk({cpl_cid, cpl_type, cpl_info, cpl_lid} == {ecid, eevt}, cur_req,
                    "completion cid/type/info/lid", {cpl_cid, cpl_type, cpl_info, cpl_lid}, {ecid, eevt});
                chk(cpl_status == 8'h00, "R6", "cpl_status", cpl_status, 0);
            end
            chk(rej_valid == erv, cur_req, "rej_valid", rej_valid, erv);
            if (erv && rej_valid) begin
                chk(rej_cid == ercid, cur_req, "rej_cid", rej_cid, ercid);
                chk(rej_status == 8'h05, "R1", "rej_status", rej_status, 5);
            end
        end
    end

    task automatic step(); @(negedge clk); endtask
    task automatic idle(input int n); repeat (n) step(); endtask
    task automatic do_req(input logic [15:0] c);
        req_valid = 1; req_cid = c; step(); req_valid = 0;
    endtask
    task automatic do_post(input logic [7:0] t, input logic [7:0] inf, input logic [7:0] l);
        evt_valid = 1; evt_type = t; evt_info = inf; evt_lid = l; step(); evt_valid = 0;
    endtask
    task automatic do_clr(input logic [2:0] t);
        clr_valid = 1; clr_type = t; step(); clr_valid = 0;
    endtask
    task automatic do_creset(); ctrl_reset = 1; step(); ctrl_reset = 0; endtask
    task automatic clr_all(); for (int t = 0; t < 8; t++) do_clr(3'(t)); endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        finish_run();
    end

    logic [15:0] held_cid;

    initial begin
        idle(3);
        rst_n = 1;
        step();
        // R11: state after power-on reset
        chk(!cpl_valid && !rej_valid, "R11", "outputs after reset", {cpl_valid, rej_valid}, 0);
        checking = 1;

        cur_req = "R2";
        do_req(16'd100);
        idle(3);
        chk(!cpl_valid, "R2", "no completion for bare request", cpl_valid, 0);

        cur_req = "R7";
        do_post(8'd0, 8'h01, 8'h01);
        chk(!cpl_valid, "R7", "completion not before edge k+1", cpl_valid, 0);
        step();
        chk(cpl_valid && cpl_cid == 16'd100, "R7", "completion after post", cpl_cid, 100);
        cur_req = "R6";
        idle(2);
        do_clr(3'd0);

        cur_req = "R3";
        do_creset();
        do_req(16'd1); do_req(16'd2); do_req(16'd3);
        do_post(8'd0, 8'h10, 8'h01);
        step();
        chk(cpl_valid && cpl_cid == 16'd3, "R3", "newest request first", cpl_cid, 3);
        do_post(8'd1, 8'h11, 8'h02);
        do_post(8'd6, 8'h12, 8'h0c);
        idle(3);

        cur_req = "R5";
        do_post(8'd6, 8'h09, 8'h0c);
        do_post(8'd7, 8'h03, 8'h0d);
        do_req(16'd50);
        step();
        chk(cpl_valid && cpl_type == 8'd7, "R5", "masked older event skipped", cpl_type, 7);
        do_req(16'd51);
        idle(2);
        chk(!cpl_valid, "R5", "masked event held back", cpl_valid, 0);
        cur_req = "R8";
        do_clr(3'd6);
        step();
        chk(cpl_valid && cpl_cid == 16'd51 && cpl_info == 8'h09, "R8", "clear releases event", cpl_info, 9);
        idle(2);

        cur_req = "R1";
        do_creset();
        do_req(16'd20); do_req(16'd21); do_req(16'd22); do_req(16'd23);
        do_req(16'd24);
        chk(rej_valid && rej_cid == 16'd24, "R1", "over-limit request refused", rej_cid, 24);
        idle(2);

        cur_req = "R4";
        do_creset();
        clr_all();
        for (int i = 0; i < 10; i++) do_post(8'(i % 8), 8'(i), 8'h40);
        for (int i = 0; i < 4; i++) do_req(16'(200 + i));
        idle(6);
        for (int i = 0; i < 4; i++) do_req(16'(210 + i));
        idle(6);
        clr_all();
        do_req(16'd220);
        idle(4);
        chk(!cpl_valid, "R4", "events posted when full were dropped", cpl_valid, 0);

        cur_req = "R10";
        do_creset();
        clr_all();
        cpl_ready = 0;
        do_req(16'd300); do_req(16'd301);
        do_post(8'd2, 8'h22, 8'h01);
        do_post(8'd3, 8'h33, 8'h01);
        step();
        held_cid = cpl_cid;
        idle(3);
        chk(cpl_valid && cpl_cid == held_cid && cpl_cid == 16'd301, "R10", "completion held under backpressure", cpl_cid, 301);
        cpl_ready = 1;
        idle(4);

        cur_req = "R9";
        do_req(16'd400); do_req(16'd401);
        do_post(8'd2, 8'h01, 8'h01);
        do_creset();
        clr_all();
        do_post(8'd5, 8'h05, 8'h05);
        idle(3);
        chk(!cpl_valid, "R9", "requests dropped by controller reset", cpl_valid, 0);
        do_req(16'd402);
        step();
        chk(cpl_valid && cpl_cid == 16'd402 && cpl_type == 8'd5, "R9", "queue refilled after reset", cpl_cid, 402);
        idle(3);

        checking = 0;
        finish_run();
    end

endmodule